// File: doc/BRIEF.md
# Transmit Descriptor Ring Pointer Bank

This block holds the address of the current transmit buffer descriptor for each of eight descriptor rings. Software programs a base address per ring. From then on the pointer moves by itself, driven by strobes from the transmit DMA engine. Each successful descriptor close steps the pointer forward by one 8-byte descriptor. A close of the ring's final descriptor sends it back to the ring base. A frame aborted on error returns it to the descriptor that opened that frame.

The DMA engine names one ring per cycle and marks four kinds of event on it: frame start, descriptor close, end-of-ring, and abort. At each frame start the block records the pointer as the frame's first-descriptor address, so that an abort can roll back to it. Software can also overwrite a pointer directly, but only while the transmitter is quiet. A write attempted at any other time is refused and flagged. All pointers are aligned to 8 bytes. Every pointer is visible on a flat output bus and through a combinational read port that selects one ring.

Top module: `txr_ring_ptr`

## Requirements
- R1: There are eight independent 32-bit pointers. After a synchronous active-low reset, every pointer, every base and every first-descriptor address is zero.
- R2: A base write to ring n (`base_wr_en`=1, `base_wr_ring`=n) stores the aligned value as ring n's base and loads it into ring n's pointer on the next clock edge. No other ring changes.
- R3: A descriptor close on ring n (`dma_close`=1, `dma_last`=0) advances ring n's pointer by 8.
- R4: A descriptor close with `dma_last`=1 reloads ring n's pointer from ring n's stored base instead of adding 8.
- R5: Bits [2:0] of every pointer and every base always read as zero. Any ones written into those bits by a base write or a pointer write are discarded.
- R6: A frame-start strobe (`dma_sof`=1) on ring n records ring n's pointer value from before that edge. A later `dma_abort` on ring n returns the pointer to that recorded address.
- R7: A software pointer write (`ptr_wr_en`=1) loads the aligned value into ring `ptr_wr_ring` only when `tx_quiet`=1.
- R8: A software pointer write while `tx_quiet`=0 leaves every pointer unchanged. It raises `wr_reject` for exactly the next cycle; `wr_reject` is otherwise 0.
- R9: When several updates target the same ring in one cycle, they take effect in this order: base write first, then accepted pointer write, then abort, then close.
- R10: `rd_data` shows, in the same cycle, the pointer of the ring selected by `rd_ring`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_wr_en | input | 1 | Base register write strobe |
| base_wr_ring | input | 3 | Ring selected for the base write |
| base_wr_data | input | 32 | New base address |
| ptr_wr_en | input | 1 | Software pointer write strobe |
| ptr_wr_ring | input | 3 | Ring selected for the pointer write |
| ptr_wr_data | input | 32 | New pointer value |
| tx_quiet | input | 1 | Transmitter disabled or stopped with no buffer in use |
| dma_ring | input | 3 | Ring named by the DMA event strobes |
| dma_sof | input | 1 | Frame start on dma_ring |
| dma_close | input | 1 | Descriptor closed successfully on dma_ring |
| dma_last | input | 1 | Closed descriptor is the end of its ring |
| dma_abort | input | 1 | Frame aborted on error on dma_ring |
| rd_ring | input | 3 | Ring selected for the software read view |
| rd_data | output | 32 | Pointer of rd_ring |
| cur_ptr | output | 256 | All pointers, ring n at bits [32n+31:32n] |
| wr_reject | output | 1 | One-cycle flag for a refused pointer write |

## Verification
The pointer update is tried first with plain close runs, which separate the +8 step from the end-of-ring reload. A frame-start, close and abort sequence then shows that rollback targets the recorded first descriptor and not the base. Base and pointer writes with low bits set show that alignment is enforced. Pointer writes made with and without the quiet condition tell an accepted load from a refused one. Same-ring collisions in a single cycle expose the update order. A long pseudo-random mix of all strobes across rings, compared every cycle against a behavioural model, catches leakage between rings and mistakes in the read-port selection.

// File: rtl/txr_pkg.sv
// Shared constants and types for the transmit descriptor ring pointer bank.
// Assumes descriptors are a power-of-two number of bytes, given by TXR_ALIGN.
package txr_pkg;
    localparam int TXR_RINGS  = 8;
    localparam int TXR_ADDR_W = 32;
    localparam int TXR_ALIGN  = 3;

    // Source selected for a pointer's next value
    typedef enum logic [2:0] {
        SRC_HOLD,
        SRC_BASE,
        SRC_SW,
        SRC_ROLLBACK,
        SRC_STEP,
        SRC_WRAP
    } txr_src_e;
endpackage

// File: rtl/txr_wr_guard.sv
// Gate for software pointer writes. A write is accepted only while the
// transmitter is quiet. A refused write raises wr_reject for one cycle.
// Assumes tx_quiet is synchronous to clk.
module txr_wr_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic ptr_wr_en,
    input  logic tx_quiet,
    output logic accept,
    output logic wr_reject
);
    // Acceptance decision for the current cycle
    always_comb accept = ptr_wr_en && tx_quiet;

    // Registered flag for a refused write
    always_ff @(posedge clk) begin
        if (!rst_n) wr_reject <= 1'b0;
        else        wr_reject <= ptr_wr_en && !tx_quiet;
    end

    // R8
    reject_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_wr_en && !tx_quiet) |=> wr_reject);
    // R8
    reject_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ptr_wr_en && !tx_quiet) |=> !wr_reject);
endmodule

// File: rtl/txr_ring_slot.sv
// Pointer, base and first-descriptor storage for one descriptor ring.
// Assumes its load and event strobes are already decoded for this ring.
// Update order: base load, software load, abort rollback, close step/wrap.
module txr_ring_slot
    import txr_pkg::*;
#(
    parameter int ADDR_W = TXR_ADDR_W,
    parameter int ALIGN  = TXR_ALIGN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_ld,
    input  logic [ADDR_W-1:0] base_val,
    input  logic              sw_ld,
    input  logic [ADDR_W-1:0] sw_val,
    input  logic              sof,
    input  logic              abort,
    input  logic              close,
    input  logic              last,
    output logic [ADDR_W-1:0] ptr
);
    localparam logic [ADDR_W-1:0] MASK = {ADDR_W{1'b1}} << ALIGN;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << ALIGN;

    logic [ADDR_W-1:0] base_q, first_q, ptr_q, ptr_nxt;
    txr_src_e          src;

    // Choose the update source by priority
    always_comb begin
        if (base_ld)      src = SRC_BASE;
        else if (sw_ld)   src = SRC_SW;
        else if (abort)   src = SRC_ROLLBACK;
        else if (close)   src = last ? SRC_WRAP : SRC_STEP;
        else              src = SRC_HOLD;
    end

    // Form the next pointer value from the chosen source
    always_comb begin
        case (src)
            SRC_BASE:     ptr_nxt = base_val & MASK;
            SRC_SW:       ptr_nxt = sw_val & MASK;
            SRC_ROLLBACK: ptr_nxt = first_q;
            SRC_STEP:     ptr_nxt = ptr_q + STEP;
            SRC_WRAP:     ptr_nxt = base_q;
            default:      ptr_nxt = ptr_q;
        endcase
    end

    // Register pointer, base and first-descriptor address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            base_q  <= '0;
            first_q <= '0;
        end else begin
            ptr_q <= ptr_nxt;
            if (base_ld) base_q  <= base_val & MASK;
            if (sof)     first_q <= ptr_q;
        end
    end

    assign ptr = ptr_q;

    // R5
    align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q[ALIGN-1:0] == '0) && (base_q[ALIGN-1:0] == '0));
    // R2
    base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_ld |=> (ptr_q == ($past(base_val) & MASK)));
    // R3
    step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (close && !last && !abort && !sw_ld && !base_ld) |=> (ptr_q == $past(ptr_q) + STEP));
    // R4
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (close && last && !abort && !sw_ld && !base_ld) |=> (ptr_q == $past(base_q)));
    // R6
    rollback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !sw_ld && !base_ld) |=> (ptr_q == $past(first_q)));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!base_ld && !sw_ld && !abort && !close) |=> $stable(ptr_q));
endmodule

// File: rtl/txr_ring_ptr.sv
// Bank of transmit descriptor ring pointers. It decodes software writes and
// DMA event strobes per ring, keeps one slot per ring, and exposes all
// pointers plus a single-ring read view. Assumes at most one DMA ring is
// named per cycle.
module txr_ring_ptr
    import txr_pkg::*;
#(
    parameter int NUM_RINGS = TXR_RINGS,
    parameter int ADDR_W    = TXR_ADDR_W,
    parameter int ALIGN     = TXR_ALIGN,
    localparam int RING_W   = $clog2(NUM_RINGS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        base_wr_en,
    input  logic [RING_W-1:0]           base_wr_ring,
    input  logic [ADDR_W-1:0]           base_wr_data,
    input  logic                        ptr_wr_en,
    input  logic [RING_W-1:0]           ptr_wr_ring,
    input  logic [ADDR_W-1:0]           ptr_wr_data,
    input  logic                        tx_quiet,
    input  logic [RING_W-1:0]           dma_ring,
    input  logic                        dma_sof,
    input  logic                        dma_close,
    input  logic                        dma_last,
    input  logic                        dma_abort,
    input  logic [RING_W-1:0]           rd_ring,
    output logic [ADDR_W-1:0]           rd_data,
    output logic [NUM_RINGS*ADDR_W-1:0] cur_ptr,
    output logic                        wr_reject
);
    logic              sw_accept;
    logic [ADDR_W-1:0] ptr_arr [NUM_RINGS];

    txr_wr_guard u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .ptr_wr_en (ptr_wr_en),
        .tx_quiet  (tx_quiet),
        .accept    (sw_accept),
        .wr_reject (wr_reject)
    );

    for (genvar g = 0; g < NUM_RINGS; g++) begin : g_ring
        logic hit_dma;
        // Does the DMA side name this ring
        always_comb hit_dma = (dma_ring == RING_W'(g));

        txr_ring_slot #(.ADDR_W(ADDR_W), .ALIGN(ALIGN)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .base_ld  (base_wr_en && (base_wr_ring == RING_W'(g))),
            .base_val (base_wr_data),
            .sw_ld    (sw_accept && (ptr_wr_ring == RING_W'(g))),
            .sw_val   (ptr_wr_data),
            .sof      (dma_sof && hit_dma),
            .abort    (dma_abort && hit_dma),
            .close    (dma_close && hit_dma),
            .last     (dma_last),
            .ptr      (ptr_arr[g])
        );
        assign cur_ptr[g*ADDR_W +: ADDR_W] = ptr_arr[g];
    end

    // Software read view of one ring
    always_comb rd_data = ptr_arr[rd_ring];

    // R10
    rd_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data == cur_ptr[rd_ring*ADDR_W +: ADDR_W]);
endmodule

// File: tb/txr_ring_ptr_tb.sv
module txr_ring_ptr_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        base_wr_en, ptr_wr_en, tx_quiet;
    logic [2:0]  base_wr_ring, ptr_wr_ring, dma_ring, rd_ring;
    logic [31:0] base_wr_data, ptr_wr_data;
    logic        dma_sof, dma_close, dma_last, dma_abort;
    logic [31:0] rd_data;
    logic [255:0] cur_ptr;
    logic        wr_reject;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // Behavioural reference state
    logic [31:0] m_ptr [8];
    logic [31:0] m_base [8];
    logic [31:0] m_first [8];
    logic        m_rej;

    always #4 clk = ~clk;

    txr_ring_ptr u_dut (
        .clk(clk), .rst_n(rst_n),
        .base_wr_en(base_wr_en), .base_wr_ring(base_wr_ring), .base_wr_data(base_wr_data),
        .ptr_wr_en(ptr_wr_en), .ptr_wr_ring(ptr_wr_ring), .ptr_wr_data(ptr_wr_data),
        .tx_quiet(tx_quiet), .dma_ring(dma_ring), .dma_sof(dma_sof),
        .dma_close(dma_close), .dma_last(dma_last), .dma_abort(dma_abort),
        .rd_ring(rd_ring), .rd_data(rd_data), .cur_ptr(cur_ptr), .wr_reject(wr_reject)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model one clock edge from the inputs currently applied
    task automatic model_edge();
        logic [31:0] old_ptr [8];
        for (int r = 0; r < 8; r++) old_ptr[r] = m_ptr[r];
        if (!rst_n) begin
            for (int r = 0; r < 8; r++) begin
                m_ptr[r] = 0; m_base[r] = 0; m_first[r] = 0;
            end
            m_rej = 0;
            return;
        end
        for (int r = 0; r < 8; r++) begin
            logic [31:0] nb;
            nb = m_base[r];
            if (base_wr_en && base_wr_ring == r) begin
                nb = base_wr_data & 32'hFFFF_FFF8;
                m_ptr[r] = nb;
            end else if (ptr_wr_en && tx_quiet && ptr_wr_ring == r)
                m_ptr[r] = ptr_wr_data & 32'hFFFF_FFF8;
            else if (dma_abort && dma_ring == r)
                m_ptr[r] = m_first[r];
            else if (dma_close && dma_ring == r)
                m_ptr[r] = dma_last ? m_base[r] : old_ptr[r] + 32'd8;
            if (dma_sof && dma_ring == r) m_first[r] = old_ptr[r];
            m_base[r] = nb;
        end
        m_rej = ptr_wr_en && !tx_quiet;
    endtask

    // One clock: edge, model update, compare at the falling edge
    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        for (int r = 0; r < 8; r++) check(tag, cur_ptr[r*32 +: 32], m_ptr[r]);
        check("R10", rd_data, m_ptr[rd_ring]);
        check("R8", {31'd0, wr_reject}, {31'd0, m_rej});
    endtask

    task automatic idle();
        base_wr_en = 0; ptr_wr_en = 0;
        dma_sof = 0; dma_close = 0; dma_last = 0; dma_abort = 0;
    endtask

    task automatic close_on(input int r, input logic lst);
        idle(); dma_ring = 3'(r); dma_close = 1; dma_last = lst; step(); idle();
    endtask

    // Watchdog
    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0; tx_quiet = 0; base_wr_ring = 0; ptr_wr_ring = 0;
        base_wr_data = 0; ptr_wr_data = 0; dma_ring = 0; rd_ring = 0;
        for (int r = 0; r < 8; r++) begin m_ptr[r] = 'x; m_base[r] = 0; m_first[r] = 0; end
        m_rej = 0;
        step(); step();
        rst_n = 1;
        tag = "R1"; step();
        for (int r = 0; r < 8; r++) check("R1", cur_ptr[r*32 +: 32], 32'd0);

        // R2 and R5: base writes with low bits set
        tag = "R2";
        for (int r = 0; r < 8; r++) begin
            idle(); base_wr_en = 1; base_wr_ring = 3'(r);
            base_wr_data = 32'h1000_0007 + 32'(r) * 32'h100;
            step();
        end
        idle(); step();
        check("R2", cur_ptr[3*32 +: 32], 32'h1000_0300);
        check("R5", {29'd0, cur_ptr[5*32 +: 3]}, 32'd0);

        // R3: steps on ring 2
        tag = "R3";
        for (int i = 0; i < 3; i++) close_on(2, 0);
        check("R3", cur_ptr[2*32 +: 32], 32'h1000_0218);

        // R6: frame start, closes, abort
        tag = "R6";
        idle(); dma_ring = 2; dma_sof = 1; step();
        close_on(2, 0); close_on(2, 0);
        idle(); dma_ring = 2; dma_abort = 1; step(); idle();
        check("R6", cur_ptr[2*32 +: 32], 32'h1000_0218);

        // R4: end-of-ring close reloads base
        tag = "R4";
        close_on(2, 1);
        check("R4", cur_ptr[2*32 +: 32], 32'h1000_0200);

        // R8: refused write while busy
        tag = "R8";
        idle(); tx_quiet = 0; ptr_wr_en = 1; ptr_wr_ring = 4; ptr_wr_data = 32'hDEAD_BEE0; step();
        check("R8", {31'd0, wr_reject}, 32'd1);
        idle(); step();
        check("R8", cur_ptr[4*32 +: 32], 32'h1000_0400);
        check("R8", {31'd0, wr_reject}, 32'd0);

        // R7 and R5: accepted write while quiet, low bits dropped
        tag = "R7";
        tx_quiet = 1; ptr_wr_en = 1; ptr_wr_ring = 4; ptr_wr_data = 32'hDEAD_BEEF; step(); idle();
        check("R7", cur_ptr[4*32 +: 32], 32'hDEAD_BEE8);

        // R9: collisions on one ring
        tag = "R9";
        idle(); base_wr_en = 1; base_wr_ring = 6; base_wr_data = 32'h2000_0000;
        ptr_wr_en = 1; ptr_wr_ring = 6; ptr_wr_data = 32'h3000_0000;
        dma_ring = 6; dma_close = 1; dma_abort = 1; step(); idle();
        check("R9", cur_ptr[6*32 +: 32], 32'h2000_0000);
        ptr_wr_en = 1; ptr_wr_ring = 6; ptr_wr_data = 32'h3000_0040;
        dma_ring = 6; dma_abort = 1; step(); idle();
        check("R9", cur_ptr[6*32 +: 32], 32'h3000_0040);
        tx_quiet = 0;

        // Mixed pseudo-random traffic across rings
        tag = "R3";
        for (int i = 0; i < 600; i++) begin
            int k;
            idle();
            k = int'($urandom_range(0, 99));
            tx_quiet   = ($urandom_range(0, 3) == 0);
            dma_ring   = 3'($urandom_range(0, 7));
            rd_ring    = 3'($urandom_range(0, 7));
            dma_close  = (k < 55);
            dma_last   = ($urandom_range(0, 7) == 0);
            dma_sof    = ($urandom_range(0, 5) == 0);
            dma_abort  = (k >= 90);
            base_wr_en = ($urandom_range(0, 19) == 0);
            base_wr_ring = 3'($urandom_range(0, 7));
            base_wr_data = $urandom;
            ptr_wr_en  = ($urandom_range(0, 9) == 0);
            ptr_wr_ring = 3'($urandom_range(0, 7));
            ptr_wr_data = $urandom;
            step();
        end
        idle(); step();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule